// File: doc/BRIEF.md
# Manual Step and Repeat Controller

This block decides when the processor may advance to its next instruction and to its next machine cycle while an operator runs it from the console or a test panel. It holds one run trigger. A start key press sets the trigger, and the stop rules clear it at the end of an instruction or when a channel lets go. The stop rules depend on two switches. One selects automatic or manual operation. The other selects whether I/O activity may hold off a manual stop. A halt event forces the trigger off and keeps it off until the next start press.

With the continuous-enter switch on, the block tells the instruction fetch path to take every instruction from the panel keys rather than from memory. In automatic operation the start key then runs the panel instruction over and over at full speed. In manual operation, holding the multiple-step key starts one instruction at regular intervals. The interval is one of two lengths, picked by a speed switch and given as parameters in clock counts.

A separate machine-cycle key releases exactly one cycle of advance for each press while the machine is stopped in manual. The three console keys pass through synchronisers and rising-edge detectors, so holding a key counts as a single press.

Top module: `step_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `run_en`, `src_panel` and `cycle_gate` are 0.
- R2: A rising edge on `start_key` sets `run_en` within 4 clocks. A start press also clears the halted state.
- R3: With `auto_sw`=1 (automatic), an `instr_done` pulse leaves `run_en` set, whatever the other switches and `io_selected` are.
- R4: With `auto_sw`=0 (manual) and `io_ilk_auto`=0, every `instr_done` pulse clears `run_en`.
- R5: With `auto_sw`=0 and `io_ilk_auto`=1, an `instr_done` pulse clears `run_en` only when `io_selected`=0. A `chan_disconnect` pulse clears `run_en`. In automatic, `chan_disconnect` has no effect.
- R6: `src_panel` equals `cont_enter` as sampled one clock earlier. A value of 1 means panel keys and 0 means memory.
- R7: With manual, `cont_enter`=1 and `mstep_key` held, one instruction start is issued as soon as the held level is seen, and then every HI_TICKS clocks (`high_speed`=1) or LO_TICKS clocks (`high_speed`=0). Releasing the key issues no further starts.
- R8: In manual, with `run_en`=0 and not halted, each rising edge of `mcycle_key` raises `cycle_gate` for exactly one clock, however long the key is held. While `run_en` is 1, `cycle_gate` is 1.
- R9: A `halt_event` pulse clears `run_en` and blocks multiple-step starts and machine-cycle steps until the next start press. If a halt and a start edge arrive in the same clock, the halt wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_sw | input | 1 | 1 = automatic, 0 = manual |
| io_ilk_auto | input | 1 | 1 = I/O activity holds off a manual stop |
| cont_enter | input | 1 | 1 = instructions come from the panel keys |
| high_speed | input | 1 | 1 = short repeat interval |
| start_key | input | 1 | Start key, asynchronous |
| mstep_key | input | 1 | Multiple-step key, asynchronous |
| mcycle_key | input | 1 | Machine-cycle key, asynchronous |
| instr_done | input | 1 | End-of-instruction pulse |
| io_selected | input | 1 | An I/O device is selected |
| chan_disconnect | input | 1 | Channel disconnect pulse |
| halt_event | input | 1 | Halt, divide check with halt, or multiple-time error |
| run_en | output | 1 | Run trigger |
| src_panel | output | 1 | Instruction source: 1 = panel keys, 0 = memory |
| cycle_gate | output | 1 | Machine cycle advance enable |

## Verification
The interval timer is the hardest part to reach. It only counts while the multiple-step key is held, the mode is manual, continuous-enter is on and no halt is pending. Its starts are also hidden while `run_en` is already high. The bench therefore holds `instr_done` high for the whole window, so each start appears as a single clock of `run_en`. It holds the key for an exact multiple of the interval and counts those one-clock pulses for each speed setting. For the machine-cycle key, the key is held for many clocks and the bench counts the `cycle_gate` clocks, both in a clean stop and after a halt.

// File: rtl/step_pkg.sv
package step_pkg;
  localparam int NUM_KEYS = 3;
  typedef enum int unsigned {
    KEY_START  = 0,
    KEY_MSTEP  = 1,
    KEY_MCYCLE = 2
  } key_idx_e;
endpackage

// File: rtl/step_key_sync.sv
module step_key_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] key_raw,
  output logic [N-1:0] key_lvl,
  output logic [N-1:0] key_rise
);
  for (genvar k = 0; k < N; k++) begin : g_key
    logic [STAGES:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-1:0], key_raw[k]};
    end
    assign key_lvl[k]  = sh[STAGES-1];
    assign key_rise[k] = sh[STAGES-1] & ~sh[STAGES];

    // R8: an edge cannot repeat on consecutive clocks
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (rst)
      key_rise[k] |=> !key_rise[k]);
  end
endmodule

// File: rtl/step_repeat_timer.sv
module step_repeat_timer #(
  parameter int HI_TICKS = 24,
  parameter int LO_TICKS = 104
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic high_speed,
  output logic fire
);
  localparam int MAXT = (HI_TICKS > LO_TICKS) ? HI_TICKS : LO_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = high_speed ? CW'(HI_TICKS - 1) : CW'(LO_TICKS - 1);
  assign fire   = enable && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !enable)     cnt <= '0;
    else if (cnt >= lim_m1) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(MAXT));
  assert_fire_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/step_cycle_gate.sv
module step_cycle_gate (
  input  logic clk,
  input  logic rst,
  input  logic step_req,
  input  logic run_next,
  input  logic run_q,
  output logic gate_q
);
  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= run_next | step_req;
  end

  assert_step_gate_R8: assert property (@(posedge clk) disable iff (rst)
    step_req |=> gate_q);
  assert_step_once_R8: assert property (@(posedge clk) disable iff (rst)
    (gate_q && !run_q) |=> !(gate_q && !run_q));
  assert_run_gate_R8: assert property (@(posedge clk) disable iff (rst)
    run_q |-> gate_q);
endmodule

// File: rtl/step_ctrl.sv
module step_ctrl #(
  parameter int HI_TICKS    = 24,
  parameter int LO_TICKS    = 104,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_sw,
  input  logic io_ilk_auto,
  input  logic cont_enter,
  input  logic high_speed,
  input  logic start_key,
  input  logic mstep_key,
  input  logic mcycle_key,
  input  logic instr_done,
  input  logic io_selected,
  input  logic chan_disconnect,
  input  logic halt_event,
  output logic run_en,
  output logic src_panel,
  output logic cycle_gate
);
  import step_pkg::*;

  logic [NUM_KEYS-1:0] raw, lvl, rise;
  logic run_q, run_next, halted_q, fire, step_req;
  logic manual, stop_at_done, disc_stop, rep_en;

  assign raw[KEY_START]  = start_key;
  assign raw[KEY_MSTEP]  = mstep_key;
  assign raw[KEY_MCYCLE] = mcycle_key;

  step_key_sync #(.N(NUM_KEYS), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .key_raw(raw), .key_lvl(lvl), .key_rise(rise));

  assign manual = ~auto_sw;
  assign rep_en = manual & cont_enter & lvl[KEY_MSTEP] & ~halted_q;

  step_repeat_timer #(.HI_TICKS(HI_TICKS), .LO_TICKS(LO_TICKS)) i_timer (
    .clk(clk), .rst(rst), .enable(rep_en), .high_speed(high_speed), .fire(fire));

  assign stop_at_done = manual & (~io_ilk_auto | ~io_selected);
  assign disc_stop    = manual & io_ilk_auto & chan_disconnect;

  always_comb begin
    if (halt_event)                                run_next = 1'b0;
    else if (rise[KEY_START] | fire)               run_next = 1'b1;
    else if ((instr_done & stop_at_done) | disc_stop) run_next = 1'b0;
    else                                           run_next = run_q;
  end

  assign step_req = rise[KEY_MCYCLE] & manual & ~run_q & ~halted_q & ~halt_event;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      halted_q  <= 1'b0;
      src_panel <= 1'b0;
    end else begin
      run_q     <= run_next;
      src_panel <= cont_enter;
      if (halt_event)           halted_q <= 1'b1;
      else if (rise[KEY_START]) halted_q <= 1'b0;
    end
  end

  step_cycle_gate i_gate (
    .clk(clk), .rst(rst), .step_req(step_req), .run_next(run_next),
    .run_q(run_q), .gate_q(cycle_gate));

  assign run_en = run_q;

  assert_halt_clears_R9: assert property (@(posedge clk) disable iff (rst)
    halt_event |=> !run_en);
  assert_manual_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (manual && !io_ilk_auto && instr_done && !halt_event && !rise[KEY_START] && !fire)
    |=> !run_en);
  assert_auto_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (auto_sw && run_en && !halt_event) |=> run_en);
  assert_src_follow_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (src_panel == $past(cont_enter)));
endmodule

// File: tb/test_step_ctrl.sv
module test_step_ctrl;
  localparam int HI = 24;
  localparam int LO = 104;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_sw = 1'b1, io_ilk_auto = 1'b0, cont_enter = 1'b0, high_speed = 1'b1;
  logic start_key = 1'b0, mstep_key = 1'b0, mcycle_key = 1'b0;
  logic instr_done = 1'b0, io_selected = 1'b0, chan_disconnect = 1'b0, halt_event = 1'b0;
  logic run_en, src_panel, cycle_gate;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  step_ctrl #(.HI_TICKS(HI), .LO_TICKS(LO)) i_step_ctrl (
    .clk(clk), .rst(rst), .auto_sw(auto_sw), .io_ilk_auto(io_ilk_auto),
    .cont_enter(cont_enter), .high_speed(high_speed), .start_key(start_key),
    .mstep_key(mstep_key), .mcycle_key(mcycle_key), .instr_done(instr_done),
    .io_selected(io_selected), .chan_disconnect(chan_disconnect),
    .halt_event(halt_event), .run_en(run_en), .src_panel(src_panel),
    .cycle_gate(cycle_gate));

  // {auto_sw, io_ilk_auto, cont_enter, io_selected, run_en expected after instr_done}
  localparam logic [4:0] VEC [6] = '{
    5'b1_0_0_0_1,   // R3 automatic keeps running
    5'b0_0_0_0_0,   // R4 manual interlock, idle I/O
    5'b0_0_0_1_0,   // R4 manual interlock, I/O selected still stops
    5'b0_1_0_1_1,   // R5 I/O selected holds off stop
    5'b0_1_0_0_0,   // R5 no I/O selected stops
    5'b1_1_1_1_1    // R3 automatic continuous enter
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input logic act, input logic exp, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic press_start();
    start_key = 1'b1; cyc(5); start_key = 1'b0; cyc(4);
  endtask

  task automatic do_halt();
    halt_event = 1'b1; cyc(1); halt_event = 1'b0; cyc(1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int cnt;
    cyc(3);
    check(run_en, 1'b0, "R1 run_en in reset");
    check(cycle_gate, 1'b0, "R1 cycle_gate in reset");
    rst = 1'b0; cyc(1);
    check(src_panel, 1'b0, "R1 src_panel after reset");
    check(run_en, 1'b0, "R1 run_en after reset");

    // Table walk: stop rules at end of instruction
    foreach (VEC[i]) begin
      auto_sw = VEC[i][4]; io_ilk_auto = VEC[i][3];
      cont_enter = VEC[i][2]; io_selected = VEC[i][1];
      do_halt();
      press_start();
      check(run_en, 1'b1, $sformatf("R2 start sets run (vec %0d)", i));
      instr_done = 1'b1; cyc(1); instr_done = 1'b0; cyc(2);
      check(run_en, VEC[i][0], $sformatf("R3/R4/R5 run after done (vec %0d)", i));
      check(src_panel, VEC[i][2], $sformatf("R6 source select (vec %0d)", i));
    end

    // R5 disconnect in manual with I/O interlock in automatic
    auto_sw = 1'b0; io_ilk_auto = 1'b1; cont_enter = 1'b0; io_selected = 1'b1;
    do_halt(); press_start();
    check(run_en, 1'b1, "R5 run before disconnect");
    chan_disconnect = 1'b1; cyc(1); chan_disconnect = 1'b0; cyc(1);
    check(run_en, 1'b0, "R5 disconnect stops in manual");
    // R5 disconnect ignored in automatic
    auto_sw = 1'b1; press_start();
    chan_disconnect = 1'b1; cyc(1); chan_disconnect = 1'b0; cyc(1);
    check(run_en, 1'b1, "R5 disconnect ignored in automatic");

    // R9 halt beats start in the same clock
    auto_sw = 1'b1;
    start_key = 1'b1; cyc(2);
    halt_event = 1'b1; cyc(1); halt_event = 1'b0; cyc(3);
    start_key = 1'b0; cyc(1);
    check(run_en, 1'b0, "R9 halt wins over start");

    // R7 repeat at high speed: halted first, so nothing must fire
    auto_sw = 1'b0; io_ilk_auto = 1'b0; cont_enter = 1'b1; high_speed = 1'b1;
    instr_done = 1'b1;
    mstep_key = 1'b1; cnt = 0;
    repeat (50) begin @(negedge clk); if (run_en) cnt++; end
    mstep_key = 1'b0; cyc(5);
    check_int(cnt, 0, "R9 halted blocks multiple step");
    press_start(); cyc(2);  // clears halt; run dropped by instr_done
    check(run_en, 1'b0, "R4 manual stop after start");

    cnt = 0;
    mstep_key = 1'b1;
    repeat (10 * HI) begin @(negedge clk); if (run_en) cnt++; end
    mstep_key = 1'b0;
    repeat (10) begin @(negedge clk); if (run_en) cnt++; end
    check_int(cnt, 10, "R7 high speed starts");

    high_speed = 1'b0; cnt = 0;
    mstep_key = 1'b1;
    repeat (3 * LO) begin @(negedge clk); if (run_en) cnt++; end
    mstep_key = 1'b0;
    repeat (60) begin @(negedge clk); if (run_en) cnt++; end
    check_int(cnt, 3, "R7 low speed starts and release stops");
    instr_done = 1'b0;

    // R8 machine-cycle key: one cycle per press while stopped in manual
    cont_enter = 1'b0; cyc(2);
    cnt = 0; mcycle_key = 1'b1;
    repeat (20) begin @(negedge clk); if (cycle_gate) cnt++; end
    mcycle_key = 1'b0; cyc(3);
    check_int(cnt, 1, "R8 one cycle per held press");
    cnt = 0;
    for (int p = 0; p < 3; p++) begin
      mcycle_key = 1'b1;
      repeat (6) begin @(negedge clk); if (cycle_gate) cnt++; end
      mcycle_key = 1'b0;
      repeat (6) begin @(negedge clk); if (cycle_gate) cnt++; end
    end
    check_int(cnt, 3, "R8 three presses give three cycles");
    do_halt();
    cnt = 0; mcycle_key = 1'b1;
    repeat (10) begin @(negedge clk); if (cycle_gate) cnt++; end
    mcycle_key = 1'b0; cyc(3);
    check_int(cnt, 0, "R9 halted blocks machine cycle");
    auto_sw = 1'b1; press_start();
    check(cycle_gate, 1'b1, "R8 gate high while running");

    // R1 reset mid-run
    rst = 1'b1; cyc(2);
    check(run_en, 1'b0, "R1 reset clears run");
    rst = 1'b0; cyc(2);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule